// File: doc/BRIEF.md
# Split-Screen Smooth-Scroll Line Mapper

This block sits between the text-row and dot-row counters of a character display and the glyph fetch logic. For every screen position it names the display-memory text line to read and the dot row of the glyph to fetch. When the position must show nothing, it raises a blank flag instead.

The screen can be split into three bands. The first is a fixed band at the top. The second is a scrolling band whose content starts at any memory line, shifted down by 0 to 12 dot rows so that software can scroll one dot at a time. The third is a fixed band at the bottom. With scrolling active the screen shows one text line fewer than the 17 it shows when flat.

The four scroll settings are taken once per field, on the vsync strobe. If the settings are out of range or badly ordered, the block falls back to a flat one-to-one mapping. Results appear one clock after the counters are presented.

Top module: `scroll_line_mapper`

## Requirements
- R1: After reset, `line_o`, `dot_o` and `blank_o` are all 0, and the held settings are zero, which means scrolling is off.
- R2: The four settings are captured only on a clock edge where `vsync_i` is 1. Changes at any other time have no effect on the mapping until the next such edge.
- R3: With the held `end_i` value equal to 0, scrolling is off. Row r (0..16) maps to line r with the dot row unchanged, and rows 17..31 are blank.
- R4: A setting out of range gives the same flat mapping as R3. The ranges are: `ofs_i` 0..12, `first_i` 0..16, `start_i` 0..15, and `end_i` 2..17.
- R5: If the settings break the ordering `start_i < first_i < end_i` or break `end_i > start_i + 2`, the block gives the same flat mapping as R3.
- R6: When scrolling is active, rows below `start_i` map to their own line and dot row.
- R7: When scrolling is active, rows `start_i` through `end_i`-2 form the scroll band. For row r and dot row d, let s = d + `ofs_i`. The line is `first_i` + (r − `start_i`) + (s ≥ 13). The dot row is s mod 13.
- R8: A scroll-band position whose computed line is at or beyond `end_i` is blank.
- R9: When scrolling is active, rows `end_i`-1 through 15 map to line r+1 with the dot row unchanged.
- R10: When scrolling is active, rows 16 and above are blank.
- R11: Each output reflects the counters and held settings as they stood at the previous clock edge, a latency of exactly one cycle.
- R12: Whenever `blank_o` is 1, `line_o` and `dot_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Field strobe; settings are captured on edges where it is 1 |
| row_i | input | 5 | Screen text-row counter |
| dot_i | input | 4 | Dot-row counter inside the text row, 0..12 |
| ofs_i | input | 4 | Dot-row shift of the scroll band |
| first_i | input | 5 | First memory line shown in the scroll band |
| start_i | input | 5 | Screen row where the scroll band begins |
| end_i | input | 5 | Line that begins the bottom fixed band; 0 turns scrolling off |
| line_o | output | 5 | Memory line to fetch |
| dot_o | output | 4 | Glyph dot row to fetch |
| blank_o | output | 1 | Position shows nothing |

## Verification
The assertions assume that the dot-row counter never exceeds 12. In flat mode that counter passes straight through to `dot_o`, so a larger value would trip the dot range check. The row counter may take any 5-bit value. The settings may be anything, because the validity logic absorbs bad values.

The bench draws dot rows only from 0..12. It builds ordered, in-range settings constructively, so the scroll band is exercised often. Between those, it mixes in unconstrained settings to reach the fallback path.

// File: rtl/scroll_map_pkg.sv
package scroll_map_pkg;

  parameter int SM_LINE_W = 5;
  parameter int SM_DOT_W  = 4;

  typedef struct packed {
    logic [SM_DOT_W-1:0]  ofs;
    logic [SM_LINE_W-1:0] first;
    logic [SM_LINE_W-1:0] start;
    logic [SM_LINE_W-1:0] fin;
  } scroll_cfg_t;

  typedef enum logic [2:0] {
    RG_FLAT   = 3'd0,
    RG_TOP    = 3'd1,
    RG_SCROLL = 3'd2,
    RG_BOTTOM = 3'd3,
    RG_OFF    = 3'd4
  } region_t;

  // Range and ordering test for the held settings.
  function automatic logic scroll_cfg_ok(scroll_cfg_t c, int lines, int dots);
    int a;
    int b;
    int s;
    int e;
    a = int'(c.ofs);
    b = int'(c.first);
    s = int'(c.start);
    e = int'(c.fin);
    return (e != 0) && (a <= dots - 1) && (b <= lines - 1) && (s <= lines - 2) &&
           (e >= 2) && (e <= lines) && (s < b) && (b < e) && (e > s + 2);
  endfunction

  // Band of a screen row.
  function automatic region_t scroll_region(scroll_cfg_t c, logic ok, int row, int lines);
    if (!ok)                           return (row < lines) ? RG_FLAT : RG_OFF;
    if (row < int'(c.start))           return RG_TOP;
    if (row <= int'(c.fin) - 2)        return RG_SCROLL;
    if (row <= lines - 2)              return RG_BOTTOM;
    return RG_OFF;
  endfunction

endpackage

// File: rtl/scroll_cfg_shadow.sv
module scroll_cfg_shadow
  import scroll_map_pkg::*;
#(
  parameter int LINES = 17,
  parameter int DOTS  = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        vsync_i,
  input  scroll_cfg_t cfg_i,
  output scroll_cfg_t cfg_q,
  output logic        cfg_ok
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (vsync_i) cfg_q <= cfg_i;
  end

  assign cfg_ok = scroll_cfg_ok(cfg_q, LINES, DOTS);

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_i |=> $stable(cfg_q));

endmodule

// File: rtl/scroll_row_class.sv
module scroll_row_class
  import scroll_map_pkg::*;
#(
  parameter int LINES = 17
) (
  input  scroll_cfg_t          cfg,
  input  logic                 cfg_ok,
  input  logic [SM_LINE_W-1:0] row,
  output region_t              region
);

  assign region = scroll_region(cfg, cfg_ok, int'(row), LINES);

endmodule

// File: rtl/scroll_line_calc.sv
module scroll_line_calc
  import scroll_map_pkg::*;
#(
  parameter int DOTS = 13
) (
  input  scroll_cfg_t          cfg,
  input  region_t              region,
  input  logic [SM_LINE_W-1:0] row,
  input  logic [SM_DOT_W-1:0]  dot,
  output logic [SM_LINE_W-1:0] line,
  output logic [SM_DOT_W-1:0]  dot_out,
  output logic                 blank
);

  localparam int SUM_W = SM_DOT_W + 1;
  localparam int EXT_W = SM_LINE_W + 1;

  logic [SUM_W-1:0] dot_sum;
  logic             dot_carry;
  logic [SUM_W-1:0] dot_wrapped;
  logic [EXT_W-1:0] band_step;
  logic [EXT_W-1:0] scroll_line;
  logic             past_end;

  assign dot_sum     = SUM_W'(dot) + SUM_W'(cfg.ofs);
  assign dot_carry   = dot_sum >= SUM_W'(DOTS);
  assign dot_wrapped = dot_carry ? dot_sum - SUM_W'(DOTS) : dot_sum;
  assign band_step   = EXT_W'(row) - EXT_W'(cfg.start);
  assign scroll_line = EXT_W'(cfg.first) + band_step + EXT_W'(dot_carry);
  assign past_end    = scroll_line >= EXT_W'(cfg.fin);

  always_comb begin
    line    = '0;
    dot_out = '0;
    blank   = 1'b0;
    unique case (region)
      RG_FLAT, RG_TOP: begin
        line    = row;
        dot_out = dot;
      end
      RG_SCROLL: begin
        if (past_end) begin
          blank = 1'b1;
        end else begin
          line    = SM_LINE_W'(scroll_line);
          dot_out = SM_DOT_W'(dot_wrapped);
        end
      end
      RG_BOTTOM: begin
        line    = row + SM_LINE_W'(1);
        dot_out = dot;
      end
      default: blank = 1'b1;
    endcase
  end

endmodule

// File: rtl/scroll_line_mapper.sv
module scroll_line_mapper
  import scroll_map_pkg::*;
#(
  parameter int LINES = 17,
  parameter int DOTS  = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vsync_i,
  input  logic [SM_LINE_W-1:0] row_i,
  input  logic [SM_DOT_W-1:0]  dot_i,
  input  logic [SM_DOT_W-1:0]  ofs_i,
  input  logic [SM_LINE_W-1:0] first_i,
  input  logic [SM_LINE_W-1:0] start_i,
  input  logic [SM_LINE_W-1:0] end_i,
  output logic [SM_LINE_W-1:0] line_o,
  output logic [SM_DOT_W-1:0]  dot_o,
  output logic                 blank_o
);

  scroll_cfg_t          cfg_in;
  scroll_cfg_t          cfg_q;
  logic                 cfg_ok;
  region_t              region;
  logic [SM_LINE_W-1:0] line_c;
  logic [SM_DOT_W-1:0]  dot_c;
  logic                 blank_c;
  logic                 primed_q;

  assign cfg_in = '{ofs: ofs_i, first: first_i, start: start_i, fin: end_i};

  scroll_cfg_shadow #(.LINES(LINES), .DOTS(DOTS)) u_shadow (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i),
    .cfg_i(cfg_in), .cfg_q(cfg_q), .cfg_ok(cfg_ok)
  );

  scroll_row_class #(.LINES(LINES)) u_class (
    .cfg(cfg_q), .cfg_ok(cfg_ok), .row(row_i), .region(region)
  );

  scroll_line_calc #(.DOTS(DOTS)) u_calc (
    .cfg(cfg_q), .region(region), .row(row_i), .dot(dot_i),
    .line(line_c), .dot_out(dot_c), .blank(blank_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_o   <= '0;
      dot_o    <= '0;
      blank_o  <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      line_o   <= line_c;
      dot_o    <= dot_c;
      blank_o  <= blank_c;
      primed_q <= 1'b1;
    end
  end

  // R12
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_o |-> (line_o == '0) && (dot_o == '0));

  // R7
  dot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> int'(dot_o) < DOTS);

  // R4
  flat_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && !$past(cfg_ok) && int'($past(row_i)) < LINES)
      |-> (line_o == $past(row_i)) && (dot_o == $past(dot_i)) && !blank_o);

  // R10
  scroll_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $past(cfg_ok) && int'($past(row_i)) >= LINES - 1) |-> blank_o);

endmodule

// File: tb/scroll_line_mapper_tb.sv
module scroll_line_mapper_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsync_i = 1'b0;
  logic [4:0] row_i = '0;
  logic [3:0] dot_i = '0;
  logic [3:0] ofs_i = '0;
  logic [4:0] first_i = '0;
  logic [4:0] start_i = '0;
  logic [4:0] end_i = '0;
  logic [4:0] line_o;
  logic [3:0] dot_o;
  logic       blank_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  int ca = 0, cb = 0, cc = 0, cd = 0;

  always #4 clk = ~clk;

  scroll_line_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .row_i(row_i), .dot_i(dot_i),
    .ofs_i(ofs_i), .first_i(first_i), .start_i(start_i), .end_i(end_i),
    .line_o(line_o), .dot_o(dot_o), .blank_o(blank_o)
  );

  // Expected {blank, line, dot} from the requirement text, via linear dot count.
  function automatic logic [9:0] model(int row, int dot, int a, int b, int c, int d);
    bit on;
    int lin;
    int ln;
    on = (d >= 2) && (d <= 17) && (a <= 12) && (b <= 16) && (c <= 15) &&
         (c < b) && (b < d) && (d > c + 2);
    if (!on) begin
      if (row <= 16) return {1'b0, 5'(row), 4'(dot)};
      return {1'b1, 5'd0, 4'd0};
    end
    if (row >= 16) return {1'b1, 5'd0, 4'd0};
    if (row < c) return {1'b0, 5'(row), 4'(dot)};
    if (row >= d - 1) return {1'b0, 5'(row + 1), 4'(dot)};
    lin = (row - c) * 13 + dot + a;
    ln = b + lin / 13;
    if (ln >= d) return {1'b1, 5'd0, 4'd0};
    return {1'b0, 5'(ln), 4'(lin % 13)};
  endfunction

  task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got blank=%0b line=%0d dot=%0d, expected blank=%0b line=%0d dot=%0d",
               tag, act[9], act[8:4], act[3:0], exp[9], exp[8:4], exp[3:0]);
    end
  endtask

  task automatic set_cfg(int a, int b, int c, int d);
    ofs_i = 4'(a); first_i = 5'(b); start_i = 5'(c); end_i = 5'(d);
  endtask

  task automatic load_cfg(int a, int b, int c, int d);
    set_cfg(a, b, c, d);
    ca = a; cb = b; cc = c; cd = d;
    vsync_i = 1'b1;
    @(negedge clk);
    vsync_i = 1'b0;
  endtask

  task automatic probe(string tag, int row, int dot);
    row_i = 5'(row); dot_i = 4'(dot);
    @(negedge clk);
    check(tag, {blank_o, line_o, dot_o}, model(row, dot, ca, cb, cc, cd));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    int r, dd, a, b, c, d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {blank_o, line_o, dot_o}, 10'd0);
    rst_n = 1'b1;
    @(negedge clk);
    probe("R1 settings zero -> flat", 9, 4);

    // R3: scrolling off
    load_cfg(5, 6, 3, 0);
    for (int i = 0; i < 17; i++) probe("R3 flat row", i, i % 13);
    probe("R3 row beyond screen blank", 20, 3);
    probe("R3 row 17 blank", 17, 0);

    // R4: out-of-range settings
    load_cfg(13, 6, 3, 12);  probe("R4 ofs 13", 4, 2);
    load_cfg(5, 17, 3, 12);  probe("R4 first 17", 5, 7);
    load_cfg(5, 6, 3, 18);   probe("R4 end 18", 5, 7);
    load_cfg(5, 6, 16, 17);  probe("R4 start 16", 16, 1);

    // R5: ordering failures
    load_cfg(5, 3, 2, 4);    probe("R5 end = start+2", 2, 6);
    load_cfg(5, 3, 3, 12);   probe("R5 start = first", 3, 6);
    load_cfg(5, 12, 3, 12);  probe("R5 first = end", 4, 12);

    // Scrolling active: ofs 5, first 6, start 3, end 12
    load_cfg(5, 6, 3, 12);
    probe("R6 top row", 1, 9);
    probe("R6 top row 2", 2, 0);
    probe("R7 first band row", 3, 0);
    probe("R7 carry into next line", 3, 9);
    probe("R7 exact wrap", 4, 8);
    probe("R8 carry past end blank", 8, 8);
    probe("R8 last band row blank", 10, 0);
    probe("R9 bottom first row", 11, 4);
    probe("R9 bottom last row", 15, 12);
    probe("R10 row 16 blank", 16, 0);
    probe("R10 row 31 blank", 31, 5);

    // R2: changes without vsync have no effect
    set_cfg(0, 0, 0, 0);
    probe("R2 ignored change band", 3, 9);
    probe("R2 ignored change tail", 16, 2);
    load_cfg(0, 0, 0, 0);
    probe("R2 applied on vsync", 16, 2);

    // R11: output unchanged before the edge, updated one edge later
    row_i = 5'd7; dot_i = 4'd3;
    @(posedge clk); #1;
    row_i = 5'd2; dot_i = 4'd1;
    @(negedge clk);
    check("R11 pre-edge hold", {blank_o, line_o, dot_o}, model(7, 3, ca, cb, cc, cd));
    @(negedge clk);
    check("R11 one-cycle update", {blank_o, line_o, dot_o}, model(2, 1, ca, cb, cc, cd));

    // Constrained random valid settings
    for (int k = 0; k < 300; k++) begin
      c = $urandom % 14;
      d = c + 3 + ($urandom % (15 - c));
      b = c + 1 + ($urandom % (d - c - 1));
      a = $urandom % 13;
      load_cfg(a, b, c, d);
      for (int j = 0; j < 8; j++) begin
        r = $urandom % 18; dd = $urandom % 13;
        probe("R7/R8/R9 random scroll", r, dd);
      end
    end

    // Unconstrained settings, fallback or scroll
    for (int k = 0; k < 300; k++) begin
      load_cfg($urandom % 16, $urandom % 32, $urandom % 32, $urandom % 32);
      for (int j = 0; j < 4; j++) begin
        r = $urandom % 32; dd = $urandom % 13;
        probe("R4/R5 random settings", r, dd);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule